// File: doc/BRIEF.md
# Disk head seek controller

This block executes the head-positioning commands of a floppy disk controller. A host writes a current-track register, a target register and a command byte. The controller then issues step pulses with a direction level at a programmable rate until the head reaches the target. The track register moves one count with each pulse. Single-step commands issue exactly one pulse. Homing drives the head to track zero.

After positioning, the controller can optionally confirm the head position. It compares the track number of the next sector ID field seen by the read channel against its own track register, and the ID field must also carry a good CRC. A busy status bit covers the whole command. Completion clears busy and raises an interrupt line, and a failed confirmation sets a seek-error status bit. An abort command is honoured at any time. All other commands are refused while busy.

Top module: `head_seek_ctrl`

## Requirements
- R1: After reset `status_o` is 8'h04, `track_o`, `data_o`, `intrq_o` and `step_o` are 0.
- R2: A command byte written while busy (status bit 0) is clear is accepted, and busy reads 1 from the next clock edge. The command byte fields are: opcode in bits 7..5, a select/update flag in bit 4, a confirm flag in bit 2, and the rate code in bits 1..0.
- R3: Opcode 000 with bit 4 = 1 (seek) steps toward `data_o`. Each step changes `track_o` by one. `dir_o` is 1 when the target is above the track and 0 otherwise. The command completes with no pulse when the two are already equal.
- R4: Opcode 000 with bit 4 = 0 (home) seeks to track 0 and leaves `data_o` unchanged.
- R5: Each step pulse lasts one cycle. Successive pulses of one seek are spaced by the rate time times `CYC_PER_MS` cycles, where the rate code gives 6, 12, 20 or 30 ms for 00, 01, 10 or 11.
- R6: Opcodes 001 (repeat last direction), 010 (inward, `dir_o`=1) and 011 (outward, `dir_o`=0) issue exactly one pulse. `track_o` follows that pulse only when bit 4 is 1.
- R7: With bit 2 set, after positioning the controller takes the first ID field offered on `id_valid`. If its track differs from `track_o` or its CRC flag is 0, status bit 4 (seek error) is set, and the interrupt is still raised.
- R8: At completion busy clears and `intrq_o` rises on the same edge. `intrq_o` falls when the next command is accepted.
- R9: A command with bits 7..4 = 1101 (abort) is accepted even while busy. From the next edge busy is 0, `intrq_o` is 1, and no further pulse occurs.
- R10: While busy, other commands and writes to the track and target registers have no effect.
- R11: Command bytes with bits 7..4 of 1000 to 1100, 1110 or 1111 are ignored: busy stays 0, `intrq_o` is unchanged and no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_in | input | 8 | Command byte |
| trk_we | input | 1 | Track register write strobe |
| trk_in | input | TW | Track register write value |
| dat_we | input | 1 | Target register write strobe |
| dat_in | input | TW | Target register write value |
| id_valid | input | 1 | An ID field is being offered |
| id_track | input | TW | Track number read from the ID field |
| id_crc_ok | input | 1 | ID field CRC was good |
| step_o | output | 1 | Step pulse, one cycle |
| dir_o | output | 1 | Step direction, 1 = toward higher tracks |
| intrq_o | output | 1 | Completion interrupt |
| track_o | output | TW | Track register |
| data_o | output | TW | Target register |
| status_o | output | 8 | Bit 0 busy, bit 2 at track 0, bit 4 seek error |

## Verification
The bench targets several corner cases, each tied to a plausible design error:
- A seek whose target equals the current track must finish without a pulse. A design that tests equality after stepping would overshoot by one track.
- Pulse spacing is measured for all four rate codes. An off-by-one in the delay counter would show as every interval being one cycle long or short.
- The repeat-step command must reuse the direction of the previous command. A design that resets the direction would step the wrong way.
- The abort command, and register writes made while busy, are checked through `track_o` and `data_o`. A controller that obeys a late command would move the head or retarget it.
- Confirmation is checked with both a mismatching track and a bad CRC flag. A design that ignored the CRC flag would report success.

// File: rtl/seek_pkg.sv
package seek_pkg;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_HOME,
        CK_SEEK,
        CK_STEP,
        CK_STEP_IN,
        CK_STEP_OUT,
        CK_ABORT
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_WAIT,
        ST_CONFIRM
    } seq_state_e;

    localparam int STAT_BUSY    = 0;
    localparam int STAT_TRK0    = 2;
    localparam int STAT_SEEKERR = 4;

    // Step interval in milliseconds for each rate code
    function automatic int rate_ms(input logic [1:0] code);
        case (code)
            2'b00:   return 6;
            2'b01:   return 12;
            2'b10:   return 20;
            default: return 30;
        endcase
    endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import seek_pkg::*;
(
    input  logic [7:0] cmd,
    output cmd_kind_e  kind,
    output logic [1:0] rate,
    output logic       confirm,
    output logic       upd
);
    logic unused_bit;
    assign unused_bit = cmd[3];

    always_comb begin
        rate    = cmd[1:0];
        confirm = cmd[2];
        upd     = cmd[4];
        case (cmd[7:5])
            3'b000:  kind = cmd[4] ? CK_SEEK : CK_HOME;
            3'b001:  kind = CK_STEP;
            3'b010:  kind = CK_STEP_IN;
            3'b011:  kind = CK_STEP_OUT;
            3'b110:  kind = cmd[4] ? CK_ABORT : CK_NONE;
            default: kind = CK_NONE;
        endcase
    end
endmodule

// File: rtl/step_rate_timer.sv
module step_rate_timer
    import seek_pkg::*;
#(
    parameter int CYC_PER_MS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] rate,
    output logic       done
);
    localparam int MAXC = 30 * CYC_PER_MS;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // Loaded on the pulse cycle; two cycles of sequencing complete the period
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(rate_ms(rate) * CYC_PER_MS - 2);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/head_seek_ctrl.sv
module head_seek_ctrl
    import seek_pkg::*;
#(
    parameter int CYC_PER_MS = 1000,
    parameter int TW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [7:0]    cmd_in,
    input  logic          trk_we,
    input  logic [TW-1:0] trk_in,
    input  logic          dat_we,
    input  logic [TW-1:0] dat_in,
    input  logic          id_valid,
    input  logic [TW-1:0] id_track,
    input  logic          id_crc_ok,
    output logic          step_o,
    output logic          dir_o,
    output logic          intrq_o,
    output logic [TW-1:0] track_o,
    output logic [TW-1:0] data_o,
    output logic [7:0]    status_o
);
    typedef struct packed {
        seq_state_e    st;
        logic          busy;
        logic          intrq;
        logic          step;
        logic          dir;
        logic          serr;
        logic          single;
        logic          confirm;
        logic          upd;
        logic [1:0]    rate;
        logic [TW-1:0] track;
        logic [TW-1:0] data;
        logic [TW-1:0] target;
    } regs_t;

    regs_t r_d, r_q;

    cmd_kind_e  kind;
    logic [1:0] c_rate;
    logic       c_confirm;
    logic       c_upd;
    logic       tmr_load;
    logic       tmr_done;
    logic       accept;
    logic       dir_n;

    cmd_decode u_dec (
        .cmd     (cmd_in),
        .kind    (kind),
        .rate    (c_rate),
        .confirm (c_confirm),
        .upd     (c_upd)
    );

    step_rate_timer #(.CYC_PER_MS(CYC_PER_MS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .rate  (r_q.rate),
        .done  (tmr_done)
    );

    assign accept = cmd_we && ((kind == CK_ABORT) || (kind != CK_NONE && !r_q.busy));

    always_comb begin
        r_d      = r_q;
        r_d.step = 1'b0;
        tmr_load = 1'b0;
        dir_n    = r_q.dir;

        // Host register writes only while idle
        if (!r_q.busy) begin
            if (trk_we) r_d.track = trk_in;
            if (dat_we) r_d.data  = dat_in;
        end

        case (r_q.st)
            ST_DECIDE: begin
                if (!r_q.single && r_q.track == r_q.target) begin
                    if (r_q.confirm) begin
                        r_d.st = ST_CONFIRM;
                    end else begin
                        r_d.st    = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.intrq = 1'b1;
                    end
                end else begin
                    if (!r_q.single) dir_n = (r_q.target > r_q.track);
                    r_d.dir  = dir_n;
                    r_d.step = 1'b1;
                    if (r_q.upd) r_d.track = dir_n ? r_q.track + 1'b1 : r_q.track - 1'b1;
                    tmr_load = 1'b1;
                    r_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tmr_done) begin
                    if (!r_q.single) begin
                        r_d.st = ST_DECIDE;
                    end else if (r_q.confirm) begin
                        r_d.st = ST_CONFIRM;
                    end else begin
                        r_d.st    = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.intrq = 1'b1;
                    end
                end
            end
            ST_CONFIRM: begin
                if (id_valid) begin
                    r_d.serr  = (id_track != r_q.track) || !id_crc_ok;
                    r_d.st    = ST_IDLE;
                    r_d.busy  = 1'b0;
                    r_d.intrq = 1'b1;
                end
            end
            default: ;
        endcase

        if (accept) begin
            if (kind == CK_ABORT) begin
                r_d.st    = ST_IDLE;
                r_d.busy  = 1'b0;
                r_d.intrq = 1'b1;
                r_d.step  = 1'b0;
            end else begin
                r_d.st      = ST_DECIDE;
                r_d.busy    = 1'b1;
                r_d.intrq   = 1'b0;
                r_d.serr    = 1'b0;
                r_d.rate    = c_rate;
                r_d.confirm = c_confirm;
                r_d.single  = (kind == CK_STEP) || (kind == CK_STEP_IN) || (kind == CK_STEP_OUT);
                r_d.upd     = (kind == CK_SEEK) || (kind == CK_HOME) || c_upd;
                r_d.target  = (kind == CK_HOME) ? '0 : r_q.data;
                if (kind == CK_STEP_IN)  r_d.dir = 1'b1;
                if (kind == CK_STEP_OUT) r_d.dir = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign step_o  = r_q.step;
    assign dir_o   = r_q.dir;
    assign intrq_o = r_q.intrq;
    assign track_o = r_q.track;
    assign data_o  = r_q.data;

    always_comb begin
        status_o               = '0;
        status_o[STAT_BUSY]    = r_q.busy;
        status_o[STAT_TRK0]    = (r_q.track == '0);
        status_o[STAT_SEEKERR] = r_q.serr;
    end
endmodule

// File: rtl/seek_chk.sv
module seek_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step,
    input logic          busy,
    input logic          intrq,
    input logic [TW-1:0] track
);
    // R5
    step_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step ##1 !step);

    // R5
    step_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> busy);

    // R3
    track_unit_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
        (track == $past(track) || track == $past(track) + 1'b1 || track == $past(track) - 1'b1));

    // R8
    done_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> intrq);

    // R8
    irq_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intrq |-> !busy);
endmodule

bind head_seek_ctrl seek_chk #(.TW(TW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step_o),
    .busy  (status_o[0]),
    .intrq (intrq_o),
    .track (track_o)
);

// File: tb/head_seek_ctrl_tb.sv
module head_seek_ctrl_tb;
    localparam int CPM = 2;
    localparam int TW  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_we;
    logic [7:0]    cmd_in;
    logic          trk_we;
    logic [TW-1:0] trk_in;
    logic          dat_we;
    logic [TW-1:0] dat_in;
    logic          id_valid;
    logic [TW-1:0] id_track;
    logic          id_crc_ok;
    logic          step_o;
    logic          dir_o;
    logic          intrq_o;
    logic [TW-1:0] track_o;
    logic [TW-1:0] data_o;
    logic [7:0]    status_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 1'b0;

    always #2 clk = ~clk;

    head_seek_ctrl #(.CYC_PER_MS(CPM), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_in(cmd_in),
        .trk_we(trk_we), .trk_in(trk_in),
        .dat_we(dat_we), .dat_in(dat_in),
        .id_valid(id_valid), .id_track(id_track), .id_crc_ok(id_crc_ok),
        .step_o(step_o), .dir_o(dir_o), .intrq_o(intrq_o),
        .track_o(track_o), .data_o(data_o), .status_o(status_o)
    );

    typedef struct packed {
        logic [7:0] trk;
        logic [7:0] dat;
        logic [7:0] cmd;
        logic [7:0] idt;
        logic       crc;
        logic [7:0] etrk;
        logic [7:0] estp;
        logic       edir;
        logic       eerr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'd3,  8'd7,  8'h10, 8'd0, 1'b1, 8'd7,  8'd4, 1'b1, 1'b0}, // R3 up, rate 00
        '{8'd9,  8'd5,  8'h11, 8'd0, 1'b1, 8'd5,  8'd4, 1'b0, 1'b0}, // R3 down, rate 01
        '{8'd12, 8'd12, 8'h10, 8'd0, 1'b1, 8'd12, 8'd0, 1'b0, 1'b0}, // R3 already there
        '{8'd3,  8'd40, 8'h00, 8'd0, 1'b1, 8'd0,  8'd3, 1'b0, 1'b0}, // R4 home
        '{8'd2,  8'd4,  8'h14, 8'd4, 1'b1, 8'd4,  8'd2, 1'b1, 1'b0}, // R7 confirm ok
        '{8'd2,  8'd4,  8'h14, 8'd5, 1'b1, 8'd4,  8'd2, 1'b1, 1'b1}, // R7 track mismatch
        '{8'd6,  8'd6,  8'h14, 8'd6, 1'b0, 8'd6,  8'd0, 1'b1, 1'b1}, // R7 bad CRC
        '{8'd10, 8'd0,  8'h50, 8'd0, 1'b1, 8'd11, 8'd1, 1'b1, 1'b0}, // R6 inward, update
        '{8'd10, 8'd0,  8'h60, 8'd0, 1'b1, 8'd10, 8'd1, 1'b0, 1'b0}, // R6 outward, no update
        '{8'd10, 8'd0,  8'h30, 8'd0, 1'b1, 8'd9,  8'd1, 1'b0, 1'b0}, // R6 repeat direction
        '{8'd8,  8'd0,  8'h74, 8'd7, 1'b1, 8'd7,  8'd1, 1'b0, 1'b0}, // R6 R7 outward + confirm
        '{8'd0,  8'd2,  8'h13, 8'd0, 1'b1, 8'd2,  8'd2, 1'b1, 1'b0}, // R5 rate 11
        '{8'd1,  8'd3,  8'h12, 8'd0, 1'b1, 8'd3,  8'd2, 1'b1, 1'b0}  // R5 rate 10
    };

    function automatic int period_of(input logic [1:0] code);
        case (code)
            2'b00:   return 6 * CPM;
            2'b01:   return 12 * CPM;
            2'b10:   return 20 * CPM;
            default: return 30 * CPM;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_regs(input logic [7:0] t, input logic [7:0] d);
        @(negedge clk);
        trk_we = 1'b1; trk_in = t;
        dat_we = 1'b1; dat_in = d;
        @(negedge clk);
        trk_we = 1'b0; dat_we = 1'b0;
    endtask

    task automatic issue(input logic [7:0] c);
        @(negedge clk);
        cmd_we = 1'b1; cmd_in = c;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    // Samples at negedges until the interrupt is seen
    task automatic wait_irq(input int period, input bit dchk, input logic edir, output int steps);
        int cyc;
        int last;
        cyc = 0; last = 0; steps = 0;
        while (!intrq_o && cyc < 4000) begin
            if (step_o) begin
                steps++;
                if (dchk) chk("R3", "direction at pulse", int'(dir_o), int'(edir));
                if (steps > 1 && period > 0) chk("R5", "pulse spacing", cyc - last, period);
                last = cyc;
            end
            @(negedge clk);
            cyc++;
        end
        chk("R8", "interrupt at completion", int'(intrq_o), 1);
    endtask

    task automatic count_pulses(input int ncyc, output int steps);
        steps = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (step_o) steps++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int steps;
        rst_n = 1'b0;
        cmd_we = 1'b0; cmd_in = '0;
        trk_we = 1'b0; trk_in = '0;
        dat_we = 1'b0; dat_in = '0;
        id_valid = 1'b1; id_track = '0; id_crc_ok = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "status after reset", int'(status_o), 8'h04);
        chk("R1", "track after reset", int'(track_o), 0);
        chk("R1", "target after reset", int'(data_o), 0);
        chk("R1", "intrq after reset", int'(intrq_o), 0);
        chk("R1", "step after reset", int'(step_o), 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            set_regs(VECS[v].trk, VECS[v].dat);
            id_track  = VECS[v].idt;
            id_crc_ok = VECS[v].crc;
            issue(VECS[v].cmd);
            chk("R2", "busy after accept", int'(status_o[0]), 1);
            chk("R8", "intrq cleared by accept", int'(intrq_o), 0);
            wait_irq(period_of(VECS[v].cmd[1:0]), 1'b1, VECS[v].edir, steps);
            chk("R3", "pulse count", steps, int'(VECS[v].estp));
            chk("R3", "final track", int'(track_o), int'(VECS[v].etrk));
            chk("R4", "target unchanged", int'(data_o), int'(VECS[v].dat));
            chk("R7", "seek error bit", int'(status_o[4]), int'(VECS[v].eerr));
            chk("R8", "busy cleared", int'(status_o[0]), 0);
            if (VECS[v].estp != 0) chk("R6", "final direction", int'(dir_o), int'(VECS[v].edir));
        end

        // R10 commands and register writes while busy
        set_regs(8'd0, 8'd5);
        issue(8'h13);
        repeat (5) @(negedge clk);
        cmd_we = 1'b1; cmd_in = 8'h00;
        trk_we = 1'b1; trk_in = 8'd50;
        dat_we = 1'b1; dat_in = 8'd60;
        @(negedge clk);
        cmd_we = 1'b0; trk_we = 1'b0; dat_we = 1'b0;
        chk("R10", "target write while busy", int'(data_o), 5);
        wait_irq(0, 1'b0, 1'b0, steps);
        chk("R10", "track after ignored writes", int'(track_o), 5);
        chk("R10", "target after ignored writes", int'(data_o), 5);

        // R9 abort while busy
        set_regs(8'd0, 8'd20);
        issue(8'h13);
        while (!step_o) @(negedge clk);
        repeat (10) @(negedge clk);
        issue(8'hD0);
        chk("R9", "busy after abort", int'(status_o[0]), 0);
        chk("R9", "intrq after abort", int'(intrq_o), 1);
        count_pulses(200, steps);
        chk("R9", "pulses after abort", steps, 0);
        chk("R9", "track after abort", int'(track_o), 1);

        // R11 unsupported opcodes
        issue(8'h80);
        chk("R11", "busy for 8'h80", int'(status_o[0]), 0);
        chk("R11", "intrq for 8'h80", int'(intrq_o), 1);
        issue(8'hC0);
        chk("R11", "busy for 8'hC0", int'(status_o[0]), 0);
        issue(8'hE4);
        chk("R11", "busy for 8'hE4", int'(status_o[0]), 0);
        count_pulses(100, steps);
        chk("R11", "pulses after ignored opcodes", steps, 0);
        chk("R11", "track after ignored opcodes", int'(track_o), 1);
        chk("R11", "intrq kept", int'(intrq_o), 1);

        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule